// File: doc/BRIEF.md
# Selectable-Order Hard-Decision QAM Demapper

This block turns one equalized complex sample per clock into hard-decision data bits. The constellation order can change from one sample to the next, so a receiver that loads a different order on each subcarrier can drive the block straight from its equalizer output. Six orders are supported: the square sets of 16, 64 and 256 points and the cross-shaped sets of 32, 128 and 512 points.

Each sample passes through two steps. First, the in-phase and quadrature parts are each multiplied by a factor chosen for the order. The transmitter normalizes every constellation to the same average power, and this factor undoes that scaling. After it, the constellation points fall on odd multiples of 1024 in the scaled domain. Second, one bank of 23 thresholds per axis, sized for the 512-point case, places each axis on a level. A per-order offset and a clamp turn that count into a level index. Logic then maps the two level indices to Gray-coded bits. No distance metric is computed. The pipeline has five register stages.

Top module: `qam_demapper`

## Requirements
- R1: One sample is accepted on each clock. `out_valid` equals `in_valid` from exactly five clocks earlier, and each result appears five clocks after its sample.
- R2: `in_order` encoding: 0=16, 1=32, 2=64, 3=128, 4=256, 5=512 points. `out_nbits` is log2 of the point count (4, 5, 6, 7, 8, 9). Codes 6 and 7 are reserved: the result is still valid, but `out_nbits` is 0 and `out_bits` is 0.
- R3: Each axis value x is scaled to s = floor(x*F/256). F is 202, 286, 415, 580, 834 or 1163 for order codes 0 to 5.
- R4: The per-axis level count L is 4, 6, 8, 12, 16 or 24 for codes 0 to 5. The level index is floor(s/2048) + L/2, clamped to the range 0 to L-1. A value exactly on a threshold belongs to the upper level.
- R5: For square orders, each axis gives log2(L) bits equal to g ^ (g >> 1), where g is that axis's level index. The in-phase bits sit above the quadrature bits. The packed word is MSB first and right-aligned in `out_bits`.
- R6: For cross orders, let q = L/6. With in-phase level i and quadrature level j: if q <= i < 5q, then a = i - q and b = j + q. Otherwise j is clamped to the range q to 5q-1, a = j - q, and b = i (when i < q) or b = 7q + i - 5q (when i >= 5q). `out_bits` = gray(a) shifted left by log2(8q), OR gray(b).
- R7: All `out_bits` at or above position `out_nbits` are 0. While `out_valid` is low, `out_bits` and `out_nbits` are 0.
- R8: A synchronous active-high reset clears `out_valid`, `out_bits` and `out_nbits`, and drops every sample still in the pipeline.
- R9: The order is sampled together with its sample. Back-to-back samples with different orders are each decoded with their own order.
- R10: An input beyond the outermost threshold saturates to the outermost level, in either direction, on either axis.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_order | input | 3 | Constellation order code |
| in_re | input | IN_W | Signed in-phase value |
| in_im | input | IN_W | Signed quadrature value |
| out_valid | output | 1 | Result strobe |
| out_bits | output | 9 | Decided bits, right-aligned, MSB first |
| out_nbits | output | 4 | Number of meaningful bits in out_bits |

## Verification
The bench builds the block with the default 16-bit sample width. With that width, a full-scale input far exceeds the outermost threshold of every order, even after the smallest scale factor, so saturation on both signs can be reached for all six orders. The same width still allows fine input steps across each 2048-wide decision cell, which exercises values that land exactly on thresholds. Every level of every order is also visited, along with mixed-order streams that include the reserved codes.

// File: rtl/qamd_pkg.sv
`timescale 1ns/1ps
package qamd_pkg;
    localparam int SC_W    = 12;   // unsigned scale factor width
    localparam int SC_FRAC = 8;    // fractional bits of the scale factor
    localparam int UNIT_SH = 10;   // grid unit: points at odd multiples of 2**UNIT_SH
    localparam int NTHR    = 23;   // thresholds per axis for the largest order
    localparam int LEV_W   = 5;
    localparam int ORD_W   = 3;
    localparam int OUT_W   = 9;
    localparam int NB_W    = 4;

    localparam logic [ORD_W-1:0] ORD_16  = 3'd0;
    localparam logic [ORD_W-1:0] ORD_32  = 3'd1;
    localparam logic [ORD_W-1:0] ORD_64  = 3'd2;
    localparam logic [ORD_W-1:0] ORD_128 = 3'd3;
    localparam logic [ORD_W-1:0] ORD_256 = 3'd4;
    localparam logic [ORD_W-1:0] ORD_512 = 3'd5;

    typedef enum logic [1:0] {SHAPE_SQUARE, SHAPE_CROSS, SHAPE_NONE} shape_e;

    typedef struct packed {
        logic             vld;
        logic [ORD_W-1:0] ord;
    } tag_t;

    typedef struct packed {
        logic             vld;
        logic [ORD_W-1:0] ord;
        logic [LEV_W-1:0] li;
        logic [LEV_W-1:0] lq;
    } lev_t;

    function automatic shape_e shape_of(input logic [ORD_W-1:0] ord);
        case (ord)
            ORD_16, ORD_64, ORD_256:  return SHAPE_SQUARE;
            ORD_32, ORD_128, ORD_512: return SHAPE_CROSS;
            default:                  return SHAPE_NONE;
        endcase
    endfunction

    // power-normalisation factors, Q(SC_FRAC)
    function automatic logic [SC_W-1:0] scale_of(input logic [ORD_W-1:0] ord);
        case (ord)
            ORD_16:  return 12'd202;
            ORD_32:  return 12'd286;
            ORD_64:  return 12'd415;
            ORD_128: return 12'd580;
            ORD_256: return 12'd834;
            ORD_512: return 12'd1163;
            default: return '0;
        endcase
    endfunction

    function automatic int levels_of(input logic [ORD_W-1:0] ord);
        case (ord)
            ORD_16:  return 4;
            ORD_32:  return 6;
            ORD_64:  return 8;
            ORD_128: return 12;
            ORD_256: return 16;
            ORD_512: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic logic [NB_W-1:0] nbits_of(input logic [ORD_W-1:0] ord);
        if (ord > ORD_512) return '0;
        return NB_W'(int'(ord) + 4);
    endfunction

    function automatic int log2_small(input int n);
        int r;
        r = 0;
        for (int k = 0; k < 6; k++)
            if ((1 << k) == n) r = k;
        return r;
    endfunction

    function automatic int gray_of(input int v);
        return v ^ (v >> 1);
    endfunction

    function automatic logic [OUT_W-1:0] pack_bits(input logic [ORD_W-1:0] ord,
                                                   input logic [LEV_W-1:0] li,
                                                   input logic [LEV_W-1:0] lq);
        int lv, q, a, b, jc, lo_w, i, j;
        logic [OUT_W-1:0] r;
        lv = levels_of(ord);
        i = int'(li);
        j = int'(lq);
        q = 0; a = 0; b = 0; jc = 0; lo_w = 0;
        r = '0;
        case (shape_of(ord))
            SHAPE_SQUARE: begin
                lo_w = log2_small(lv);
                r = OUT_W'((gray_of(i) << lo_w) | gray_of(j));
            end
            SHAPE_CROSS: begin
                q = lv / 6;
                if (i >= q && i < 5 * q) begin
                    a = i - q;
                    b = j + q;
                end else begin
                    jc = (j < q) ? q : ((j > 5 * q - 1) ? 5 * q - 1 : j);
                    a = jc - q;
                    b = (i < q) ? i : 7 * q + i - 5 * q;
                end
                lo_w = log2_small(8 * q);
                r = OUT_W'((gray_of(a) << lo_w) | gray_of(b));
            end
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/qamd_scaler.sv
`timescale 1ns/1ps
module qamd_scaler
    import qamd_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int S_W  = IN_W + SC_W + 1 - SC_FRAC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  tag_t                   tag_in,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output tag_t                   tag_out,
    output logic signed [S_W-1:0]  s_i,
    output logic signed [S_W-1:0]  s_q
);
    localparam int P_W = IN_W + SC_W + 1;

    logic signed [SC_W:0]  fac;
    logic signed [P_W-1:0] p_i, p_q;

    assign fac = $signed({1'b0, scale_of(tag_in.ord)});
    assign p_i = in_i * fac;
    assign p_q = in_q * fac;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_out <= '0;
            s_i     <= '0;
            s_q     <= '0;
        end else begin
            tag_out <= tag_in;
            s_i     <= S_W'(p_i >>> SC_FRAC);
            s_q     <= S_W'(p_q >>> SC_FRAC);
        end
    end
endmodule

// File: rtl/qamd_slicer.sv
`timescale 1ns/1ps
module qamd_slicer
    import qamd_pkg::*;
#(
    parameter int S_W = 21
) (
    input  logic signed [S_W-1:0] s,
    output logic [NTHR-1:0]       above
);
    // thresholds at even multiples of the grid unit, centred on zero
    for (genvar k = 0; k < NTHR; k++) begin : g_thr
        localparam int THR = (k - NTHR / 2) * (2 << UNIT_SH);
        assign above[k] = (int'(s) >= THR);
    end
endmodule

// File: rtl/qamd_level.sv
`timescale 1ns/1ps
module qamd_level
    import qamd_pkg::*;
(
    input  logic [NTHR-1:0]  above,
    input  logic [ORD_W-1:0] ord,
    output logic [LEV_W-1:0] idx
);
    always_comb begin
        int cnt, lv, t;
        cnt = 0;
        for (int k = 0; k < NTHR; k++)
            cnt = cnt + int'(above[k]);
        lv = levels_of(ord);
        t  = cnt - (NTHR + 1) / 2 + lv / 2;
        if (lv == 0)       t = 0;
        else if (t < 0)    t = 0;
        else if (t > lv-1) t = lv - 1;
        idx = LEV_W'(t);
    end
endmodule

// File: rtl/qam_demapper.sv
`timescale 1ns/1ps
module qam_demapper
    import qamd_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [2:0]             in_order,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    output logic                   out_valid,
    output logic [8:0]             out_bits,
    output logic [3:0]             out_nbits
);
    localparam int S_W = IN_W + SC_W + 1 - SC_FRAC;

    // stage 1: input capture
    tag_t                  r1_tag;
    logic signed [IN_W-1:0] r1_re, r1_im;
    always_ff @(posedge clk) begin
        if (rst) begin
            r1_tag <= '0;
            r1_re  <= '0;
            r1_im  <= '0;
        end else begin
            r1_tag <= '{vld: in_valid, ord: in_order};
            r1_re  <= in_re;
            r1_im  <= in_im;
        end
    end

    // stage 2: power-normalisation scale
    tag_t                  r2_tag;
    logic signed [S_W-1:0] r2_s [2];
    qamd_scaler #(.IN_W(IN_W), .S_W(S_W)) u_scale (
        .clk(clk), .rst(rst), .tag_in(r1_tag),
        .in_i(r1_re), .in_q(r1_im),
        .tag_out(r2_tag), .s_i(r2_s[0]), .s_q(r2_s[1])
    );

    // stage 3: shared comparator bank, one per axis
    logic [NTHR-1:0] thr_c [2];
    logic [NTHR-1:0] r3_thr [2];
    tag_t            r3_tag;
    for (genvar a = 0; a < 2; a++) begin : g_axis_cmp
        qamd_slicer #(.S_W(S_W)) u_slice (.s(r2_s[a]), .above(thr_c[a]));
        always_ff @(posedge clk) begin
            if (rst) r3_thr[a] <= '0;
            else     r3_thr[a] <= thr_c[a];
        end
    end
    always_ff @(posedge clk) begin
        if (rst) r3_tag <= '0;
        else     r3_tag <= r2_tag;
    end

    // stage 4: per-order level index with saturation
    logic [LEV_W-1:0] lev_c [2];
    lev_t             r4;
    for (genvar a = 0; a < 2; a++) begin : g_axis_lev
        qamd_level u_lev (.above(r3_thr[a]), .ord(r3_tag.ord), .idx(lev_c[a]));
    end
    always_ff @(posedge clk) begin
        if (rst) r4 <= '0;
        else     r4 <= '{vld: r3_tag.vld, ord: r3_tag.ord, li: lev_c[0], lq: lev_c[1]};
    end

    // stage 5: bit mapping
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
            out_nbits <= '0;
        end else begin
            out_valid <= r4.vld;
            out_bits  <= r4.vld ? pack_bits(r4.ord, r4.li, r4.lq) : '0;
            out_nbits <= r4.vld ? nbits_of(r4.ord) : '0;
        end
    end
endmodule

// File: rtl/qamd_chk.sv
`timescale 1ns/1ps
module qamd_chk
    import qamd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] in_order,
    input logic       out_valid,
    input logic [8:0] out_bits,
    input logic [3:0] out_nbits
);
    logic [2:0] since;
    always_ff @(posedge clk) begin
        if (rst)              since <= '0;
        else if (since != 7)  since <= since + 3'd1;
    end

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    // R2
    nbits_order_chk: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd5 && out_valid) |-> (out_nbits == nbits_of($past(in_order, 5))));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_bits >> out_nbits) == 9'd0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_bits == 9'd0 && out_nbits == 4'd0));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_bits == 9'd0));
endmodule

bind qam_demapper qamd_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_order(in_order),
    .out_valid(out_valid), .out_bits(out_bits), .out_nbits(out_nbits)
);

// File: tb/tb_qam_demapper.sv
`timescale 1ns/1ps
module tb_qam_demapper;
    localparam int IN_W = 16;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic [2:0]             in_order = '0;
    logic signed [IN_W-1:0] in_re = '0;
    logic signed [IN_W-1:0] in_im = '0;
    logic                   out_valid;
    logic [8:0]             out_bits;
    logic [3:0]             out_nbits;

    qam_demapper #(.IN_W(IN_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_order(in_order),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_bits(out_bits), .out_nbits(out_nbits)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    bits;
        int    nb;
        int    cyc;
        string tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int fac_of(input int o);
        int t[6] = '{202, 286, 415, 580, 834, 1163};
        return (o < 6) ? t[o] : 0;
    endfunction

    function automatic int lev_count(input int o);
        int t[6] = '{4, 6, 8, 12, 16, 24};
        return (o < 6) ? t[o] : 0;
    endfunction

    function automatic int gr(input int v);
        return v ^ (v >> 1);
    endfunction

    function automatic int lev_of(input int x, input int o);
        int s, l, n;
        n = lev_count(o);
        s = (x * fac_of(o)) >>> 8;
        l = (s >>> 11) + n / 2;
        if (l < 0) l = 0;
        if (l > n - 1) l = n - 1;
        return l;
    endfunction

    function automatic int exp_bits(input int re, input int im, input int o);
        int i, j, n, q, a, b, w;
        if (o > 5) return 0;
        n = lev_count(o);
        i = lev_of(re, o);
        j = lev_of(im, o);
        if (o % 2 == 0) begin
            w = (o == 0) ? 2 : (o == 2) ? 3 : 4;
            return (gr(i) << w) | gr(j);
        end
        q = n / 6;
        w = (q == 1) ? 3 : (q == 2) ? 4 : 5;
        if (i < q) begin
            b = i;
            a = ((j < q) ? q : (j >= 5 * q) ? 5 * q - 1 : j) - q;
        end else if (i >= 5 * q) begin
            b = 7 * q + (i - 5 * q);
            a = ((j < q) ? q : (j >= 5 * q) ? 5 * q - 1 : j) - q;
        end else begin
            a = i - q;
            b = j + q;
        end
        return (gr(a) << w) | gr(b);
    endfunction

    task automatic send(input int re, input int im, input int o, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_order = 3'(o);
        in_re    = IN_W'(re);
        in_im    = IN_W'(im);
        it.bits  = exp_bits(re, im, o);
        it.nb    = (o > 5) ? 0 : o + 4;
        it.cyc   = cyc;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check_quiet(input string tag);
        checks++;
        if (out_valid !== 1'b0 || out_bits !== 9'd0 || out_nbits !== 4'd0) begin
            fails++;
            $display("FAIL %s: valid %0b bits %0h nbits %0d, expected 0 0 0",
                     tag, out_valid, out_bits, out_nbits);
        end
    endtask

    // monitor: compares results against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid === 1'b1) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R1: unexpected output bits %0h, expected none", out_bits);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (int'(out_bits) != it.bits || int'(out_nbits) != it.nb || cyc - it.cyc != 5) begin
                        fails++;
                        $display("FAIL %s: bits %0h nbits %0d latency %0d, expected bits %0h nbits %0d latency 5",
                                 it.tag, out_bits, out_nbits, cyc - it.cyc, it.bits, it.nb);
                    end
                end
            end else if (!rst) begin
                check_quiet("R7");
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R8");
        rst = 1'b0;
        idle(2);

        // R5 / R6: every level of every order, at point centres
        for (int o = 0; o < 6; o++) begin
            int n;
            n = lev_count(o);
            for (int l = 0; l < n; l++) begin
                int tr, tq, lq;
                lq = (l * 5 + 1) % n;
                tr = ((2 * l - n + 1) * 1024 * 256) / fac_of(o);
                tq = ((2 * lq - n + 1) * 1024 * 256) / fac_of(o);
                send(tr, tq, o, (o % 2 == 0) ? "R5" : "R6");
            end
        end
        idle(3);

        // R4: fine sweep across thresholds, 256 points
        for (int x = -24000; x <= 24000; x += 97)
            send(x, -x / 2, 4, "R4");
        // R4: exact threshold hit for 16 points (x*202/256 = 2048 at x=2596 -> floor 2048)
        send(2596, -2596, 0, "R4");
        send(2595, 2595, 0, "R4");
        idle(2);

        // R3: same raw value through every scale factor
        for (int o = 0; o < 6; o++) begin
            send(3000, -7000, o, "R3");
            send(12345, 1500, o, "R3");
        end

        // R10: full-scale saturation on both axes and signs
        for (int o = 0; o < 6; o++) begin
            send(32767, -32768, o, "R10");
            send(-32768, 32767, o, "R10");
        end
        idle(4);

        // R2: reserved order codes
        send(5000, 5000, 6, "R2");
        send(-9000, 200, 7, "R2");
        idle(1);

        // R9: back-to-back mixed orders, with gaps
        for (int k = 0; k < 48; k++) begin
            send(((k * 7919) % 65536) - 32768, ((k * 104729) % 40000) - 20000, k % 8, "R9");
            if (k % 11 == 10) idle(1);
        end
        idle(8);

        // R8: reset drops samples in flight
        send(1000, 1000, 2, "R8");
        send(2000, -2000, 3, "R8");
        send(-3000, 500, 5, "R8");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sb.delete();
        check_quiet("R8");
        rst = 1'b0;
        idle(8);
        check_quiet("R8");

        send(-20000, 20000, 5, "R6");
        idle(10);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule